// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Frame Reader

This block fetches one 40-bit measurement frame from a temperature and humidity sensor that shares a single open-drain data line with the host. A one-cycle start strobe makes the block pull the line low for a programmable wake-up period. It then lets the line float high and follows the sensor's reply edge by edge: a response low, a response high, and then forty data bits. Each bit starts with a low gap and carries its value in the width of the high pulse that follows.

The raw line goes through a synchronizer and an edge detector. A parameterized divider makes a one-microsecond tick from the system clock. High pulses longer than the threshold decode as ones, and the bits are packed most significant first into five bytes. Every read ends with a one-cycle completion pulse and an ok flag. The 40-bit output changes only when a read succeeds. A watchdog armed at release limits how long one frame can take. Checking the checksum and scaling the values are left to the consumer.

Top module: `owire_hygro_reader`

## Requirements
- R1: While reset is held and after it is released, `line_oe_o`, `done_o` and `ok_o` are 0 and `data_o` is all zeros.
- R2: A start strobe accepted in idle drives `line_oe_o` high for MARK_US microseconds, give or take one microsecond tick, and then releases it.
- R3: A start strobe that arrives while a read is in progress has no effect: the read in progress goes on unchanged and produces exactly one completion.
- R4: Line edges seen while idle are ignored: `line_oe_o` stays low, no completion is reported, and `ok_o` and `data_o` keep their values.
- R5: A high pulse measured longer than BIT_THRESH_US microseconds (default 40) decodes as 1. Any shorter pulse decodes as 0, so nominal pulses of 27 µs and 70 µs, and boundary pulses of 35 µs and 46 µs, give 0, 1, 0 and 1.
- R6: The first bit received is `data_o[39]`. Received byte k (k = 0..4) sits at `data_o[39-8k -: 8]`, each byte filled MSB first.
- R7: When a rising edge arrives after all 40 bits have been decoded, the block pulses `done_o` with `ok_o` = 1 and loads `data_o` in the same cycle.
- R8: If the frame has not completed WDOG_US microseconds after release, whether the sensor is silent or stops part way, the block pulses `done_o` with `ok_o` = 0 and returns to idle.
- R9: `done_o` lasts exactly one clock per read. `ok_o` keeps its value until the next start strobe is accepted, which clears it.
- R10: A failed read leaves `data_o` at the value of the last successful read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| line_i | input | 1 | Raw level of the data line (asynchronous) |
| line_oe_o | output | 1 | 1 = pull the data line low; 0 = release it |
| data_o | output | 40 | Last successfully received frame, first bit in bit 39 |
| done_o | output | 1 | One-cycle pulse at the end of every read |
| ok_o | output | 1 | Outcome of the last read: 1 = complete frame |

## Verification
The bench sends pulse widths on both sides of the decision point. A design that compared against the wrong threshold, or truncated the measured width, would flip bits in the 35 µs / 46 µs frame. A frame with a different bit pattern in every byte shows byte or bit order errors as a corrupted word. Start strobes are injected in the middle of a frame, and the line is toggled while idle. A block that did not guard its states would restart the wake-up pulse or report a spurious completion. Two reads that fail through the watchdog, one silent and one cut off after 20 bits, check the timeout length, the error flag, and that the previous frame stays on `data_o`.

// File: rtl/hygro_pkg.sv
package hygro_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,  // waiting for a start strobe
    ST_MARK    = 3'd1,  // host holds the line low
    ST_SETTLE  = 3'd2,  // line released, waiting for it to read high
    ST_RESP_LO = 3'd3,  // expect falling edge: sensor answers
    ST_RESP_HI = 3'd4,  // expect rising edge: answer high phase
    ST_PRE_BIT = 3'd5,  // expect falling edge before first bit
    ST_BIT_LO  = 3'd6,  // expect rising edge: bit starts or frame ends
    ST_BIT_HI  = 3'd7   // expect falling edge: bit ends
  } rd_state_e;

  // Decision rule for one data bit: strictly longer than the threshold is a 1.
  function automatic logic bit_is_one(input logic [31:0] high_us,
                                      input logic [31:0] thresh_us);
    return high_us > thresh_us;
  endfunction

  // Which byte of the frame a bit with this running index belongs to.
  function automatic logic [31:0] byte_slot(input logic [31:0] bit_idx);
    return bit_idx >> 3;
  endfunction

endpackage

// File: rtl/hygro_us_tick.sv
module hygro_us_tick #(
  parameter int CLKS_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (CLKS_PER_US <= 1) begin : g_direct
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick_o    = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLKS_PER_US);
      localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);
      logic [CW-1:0] div_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)               div_cnt <= '0;
        else if (div_cnt == LAST) div_cnt <= '0;
        else                      div_cnt <= div_cnt + 1'b1;
      end
      assign tick_o = (div_cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/hygro_line_sync.sv
module hygro_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  // Reset to the released (pulled-up) level so reset exit shows no edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], line_i};
      prev  <= chain[SYNC_STAGES-1];
    end
  end

  assign level_o = chain[SYNC_STAGES-1];
  assign rise_o  = level_o & ~prev;
  assign fall_o  = ~level_o & prev;
endmodule

// File: rtl/hygro_frame_pack.sv
module hygro_frame_pack
  import hygro_pkg::*;
#(
  parameter int FRAME_BITS = 40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       bit_valid_i,
  input  logic                       bit_val_i,
  input  logic                       commit_i,
  output logic [$clog2(FRAME_BITS+1)-1:0] bit_count_o,
  output logic [FRAME_BITS-1:0]      data_o
);
  localparam int NBYTES = FRAME_BITS / 8;
  localparam int CW     = $clog2(FRAME_BITS + 1);

  logic [CW-1:0]         bit_cnt;
  logic [FRAME_BITS-1:0] staged;
  logic                  accept;

  assign accept = bit_valid_i && (bit_cnt < CW'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) bit_cnt <= '0;
    else if (accept)       bit_cnt <= bit_cnt + 1'b1;
  end

  // One shift register per byte; the running bit index selects which one moves.
  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      logic [7:0] sr;
      logic       hit;
      assign hit = accept && (byte_slot(32'(bit_cnt)) == 32'(g));
      always_ff @(posedge clk) begin
        if (!rst_n || clear_i) sr <= '0;
        else if (hit)          sr <= {sr[6:0], bit_val_i};
      end
      assign staged[FRAME_BITS-1-8*g -: 8] = sr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        data_o <= '0;
    else if (commit_i) data_o <= staged;
  end

  assign bit_count_o = bit_cnt;
endmodule

// File: rtl/hygro_rx_fsm.sv
module hygro_rx_fsm
  import hygro_pkg::*;
#(
  parameter int MARK_US       = 18000,
  parameter int WDOG_US       = 6000,
  parameter int BIT_THRESH_US = 40,
  parameter int FRAME_BITS    = 40
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick_i,
  input  logic                            start_i,
  input  logic                            level_i,
  input  logic                            rise_i,
  input  logic                            fall_i,
  input  logic [$clog2(FRAME_BITS+1)-1:0] bit_count_i,
  output logic                            line_oe_o,
  output logic                            clear_o,
  output logic                            bit_valid_o,
  output logic                            bit_val_o,
  output logic                            commit_o,
  output logic                            done_o,
  output logic                            ok_o,
  output logic                            st_idle_o,
  output logic                            mark_end_o,
  output logic                            wd_expire_o
);
  localparam int MK_W = $clog2(MARK_US + 1);
  localparam int WD_W = $clog2(WDOG_US + 1);
  localparam int CW   = $clog2(FRAME_BITS + 1);

  rd_state_e   state, state_nx;
  logic [MK_W-1:0] mark_cnt;
  logic [WD_W-1:0] wd_cnt;
  logic [WD_W-1:0] stamp;
  logic [WD_W-1:0] high_us;
  logic        done_q, ok_q;

  logic active, want_rise, want_fall, good_edge, bad_edge;
  logic frame_full, success, failure, start_ok;

  assign start_ok   = (state == ST_IDLE) && start_i;
  assign active     = state inside {ST_SETTLE, ST_RESP_LO, ST_RESP_HI,
                                    ST_PRE_BIT, ST_BIT_LO, ST_BIT_HI};
  assign want_fall  = state inside {ST_RESP_LO, ST_PRE_BIT, ST_BIT_HI};
  assign want_rise  = state inside {ST_RESP_HI, ST_BIT_LO};
  assign good_edge  = (want_fall && fall_i) || (want_rise && rise_i);
  assign bad_edge   = (want_fall && rise_i) || (want_rise && fall_i);
  assign frame_full = (bit_count_i == CW'(FRAME_BITS));

  assign mark_end_o  = (state == ST_MARK) && tick_i &&
                       (mark_cnt == MK_W'(MARK_US - 1));
  assign wd_expire_o = active && tick_i && (wd_cnt == WD_W'(WDOG_US - 1));

  assign success = !wd_expire_o && (state == ST_BIT_LO) && rise_i && frame_full;
  assign failure = wd_expire_o || bad_edge;

  assign high_us     = wd_cnt - stamp;
  assign bit_valid_o = !wd_expire_o && (state == ST_BIT_HI) && fall_i;
  assign bit_val_o   = bit_is_one(32'(high_us), 32'(BIT_THRESH_US));
  assign clear_o     = !wd_expire_o && (state == ST_PRE_BIT) && fall_i;
  assign commit_o    = success;

  always_comb begin
    state_nx = state;
    if (failure || success) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    if (start_i)    state_nx = ST_MARK;
        ST_MARK:    if (mark_end_o) state_nx = ST_SETTLE;
        ST_SETTLE:  if (level_i)    state_nx = ST_RESP_LO;
        ST_RESP_LO: if (good_edge)  state_nx = ST_RESP_HI;
        ST_RESP_HI: if (good_edge)  state_nx = ST_PRE_BIT;
        ST_PRE_BIT: if (good_edge)  state_nx = ST_BIT_LO;
        ST_BIT_LO:  if (good_edge)  state_nx = ST_BIT_HI;
        ST_BIT_HI:  if (good_edge)  state_nx = ST_BIT_LO;
        default:                    state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mark_cnt <= '0;
      wd_cnt   <= '0;
      stamp    <= '0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= success || failure;

      if (start_ok) begin
        mark_cnt <= '0;
        ok_q     <= 1'b0;
      end else if ((state == ST_MARK) && tick_i) begin
        mark_cnt <= mark_cnt + 1'b1;
      end

      if (success)      ok_q <= 1'b1;
      else if (failure) ok_q <= 1'b0;

      if (mark_end_o)            wd_cnt <= '0;
      else if (active && tick_i) wd_cnt <= wd_cnt + 1'b1;

      if ((state == ST_BIT_LO) && rise_i) stamp <= wd_cnt;
    end
  end

  assign line_oe_o = (state == ST_MARK);
  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign st_idle_o = (state == ST_IDLE);
endmodule

// File: rtl/owire_hygro_reader.sv
module owire_hygro_reader #(
  parameter int CLKS_PER_US   = 100,
  parameter int MARK_US       = 18000,
  parameter int WDOG_US       = 6000,
  parameter int BIT_THRESH_US = 40,
  parameter int FRAME_BITS    = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  line_i,
  output logic                  line_oe_o,
  output logic [FRAME_BITS-1:0] data_o,
  output logic                  done_o,
  output logic                  ok_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic          us_tick;
  logic          line_lvl, line_rise, line_fall;
  logic          clr_bits, bit_valid, bit_val, commit;
  logic [CW-1:0] bit_count;
  // Internal events named for the bound checker.
  logic          st_idle, mark_end, wd_expire;

  hygro_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(us_tick)
  );

  hygro_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .level_o(line_lvl), .rise_o(line_rise), .fall_o(line_fall)
  );

  hygro_rx_fsm #(
    .MARK_US(MARK_US), .WDOG_US(WDOG_US),
    .BIT_THRESH_US(BIT_THRESH_US), .FRAME_BITS(FRAME_BITS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(us_tick), .start_i(start_i),
    .level_i(line_lvl), .rise_i(line_rise), .fall_i(line_fall),
    .bit_count_i(bit_count), .line_oe_o(line_oe_o), .clear_o(clr_bits),
    .bit_valid_o(bit_valid), .bit_val_o(bit_val), .commit_o(commit),
    .done_o(done_o), .ok_o(ok_o), .st_idle_o(st_idle),
    .mark_end_o(mark_end), .wd_expire_o(wd_expire)
  );

  hygro_frame_pack #(.FRAME_BITS(FRAME_BITS)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear_i(clr_bits), .bit_valid_i(bit_valid),
    .bit_val_i(bit_val), .commit_i(commit), .bit_count_o(bit_count),
    .data_o(data_o)
  );
endmodule

// File: rtl/hygro_reader_checker.sv
module hygro_reader_checker #(
  parameter int FRAME_BITS = 40
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            start_i,
  input logic                            line_oe_o,
  input logic                            done_o,
  input logic                            ok_o,
  input logic [FRAME_BITS-1:0]           data_o,
  input logic                            st_idle,
  input logic                            mark_end,
  input logic                            wd_expire,
  input logic [$clog2(FRAME_BITS+1)-1:0] bit_count
);
  AST_OE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe_o) |-> $past(st_idle && start_i)); // R2
  AST_MARK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mark_end |=> !line_oe_o); // R2
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_idle && start_i) |=> !$rose(line_oe_o)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !start_i) |=> (st_idle && !line_oe_o && !done_o)); // R4
  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= ($clog2(FRAME_BITS+1))'(FRAME_BITS)); // R6
  AST_OK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> done_o); // R7
  AST_WD_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (done_o && !ok_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DATA_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> (done_o && ok_o)); // R10
endmodule

bind owire_hygro_reader hygro_reader_checker #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_oe_o(line_oe_o),
  .done_o(done_o), .ok_o(ok_o), .data_o(data_o), .st_idle(st_idle),
  .mark_end(mark_end), .wd_expire(wd_expire), .bit_count(bit_count)
);

// File: tb/tb_owire_hygro_reader.sv
module tb_owire_hygro_reader;
  localparam int CPU    = 2;
  localparam int MARK   = 50;
  localparam int WDOG   = 6000;
  localparam int THRESH = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        sensor_low = 1'b0;
  logic        line_i;
  logic        line_oe_o, done_o, ok_o;
  logic [39:0] data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [39:0] last_good = '0;

  typedef struct { logic ok; logic [39:0] data; string tag; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  // Open-drain wire: either side can pull low.
  assign line_i = !line_oe_o && !sensor_low;

  owire_hygro_reader #(
    .CLKS_PER_US(CPU), .MARK_US(MARK), .WDOG_US(WDOG),
    .BIT_THRESH_US(THRESH), .FRAME_BITS(40)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
    .line_oe_o(line_oe_o), .data_o(data_o), .done_o(done_o), .ok_o(ok_o)
  );

  task automatic check(input logic cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Run watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      check(1'b0, "WDOG", "bench timeout", 64'(cyc), 64'(190000));
      finish_run();
    end
  end

  // Monitor: every completion pops one expected item.
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done_o)
        check(1'b0, "R9", "done longer than one cycle", 1, 0);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R4", "unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(ok_o == e.ok, e.tag, "ok flag", 64'(ok_o), 64'(e.ok));
          check(data_o == e.data, e.tag, "frame data", 64'(data_o), 64'(e.data));
        end
      end
    end
    prev_done = done_o;
  end

  task automatic wait_us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Start a read and measure the host mark (R2); also checks ok clears (R9).
  task automatic start_and_mark(input bit check_ok_clear);
    int n;
    pulse_start();
    if (check_ok_clear)
      check(ok_o == 1'b0, "R9", "ok cleared by accepted start", 64'(ok_o), 0);
    n = 0;
    while (line_oe_o) begin
      n++;
      @(negedge clk);
    end
    check(n >= (MARK - 1) * CPU && n <= MARK * CPU + 1, "R2",
          "mark length in cycles", 64'(n), 64'(MARK * CPU));
  endtask

  // Sensor answer: nbits bits, then release (only when complete).
  task automatic run_frame(input logic [39:0] val, input int hi1, input int hi0,
                           input int nbits, input bit busy_pokes, input string tag);
    exp_t e;
    logic [39:0] dec;
    for (int i = 0; i < 40; i++)
      dec[39 - i] = ((val[39 - i] ? hi1 : hi0) > THRESH);
    e.ok   = (nbits == 40);
    e.data = e.ok ? dec : last_good;
    e.tag  = tag;
    exp_q.push_back(e);
    start_and_mark(1'b1);
    wait_us(20);
    sensor_low = 1'b1; wait_us(80);
    sensor_low = 1'b0; wait_us(80);
    sensor_low = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      wait_us(50);
      sensor_low = 1'b0;
      if (busy_pokes && (i == 10 || i == 30)) pulse_start();  // R3
      wait_us(val[39 - i] ? hi1 : hi0);
      sensor_low = 1'b1;
    end
    if (nbits == 40) begin
      wait_us(50);
      sensor_low = 1'b0;
    end
    wait_empty();
    sensor_low = 1'b0;
    if (e.ok) last_good = dec;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values held during reset.
    check(line_oe_o == 1'b0, "R1", "oe in reset", 64'(line_oe_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", 64'(done_o), 0);
    check(ok_o == 1'b0, "R1", "ok in reset", 64'(ok_o), 0);
    check(data_o == '0, "R1", "data in reset", 64'(data_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(line_oe_o == 1'b0 && done_o == 1'b0 && ok_o == 1'b0, "R1",
          "outputs after reset", 64'({line_oe_o, done_o, ok_o}), 0);

    // R5 R6 R7: nominal widths, distinct byte pattern.
    run_frame(40'hA5_3C_0F_F0_81, 70, 27, 40, 1'b0, "R6/R7 nominal");
    // R5: boundary widths either side of the threshold.
    run_frame(40'h00_FF_55_AA_01, 46, 35, 40, 1'b0, "R5 boundary");

    // R4: edges while idle.
    for (int k = 0; k < 6; k++) begin
      sensor_low = ~sensor_low;
      wait_us(15);
      check(line_oe_o == 1'b0, "R4", "oe during idle edges", 64'(line_oe_o), 0);
    end
    sensor_low = 1'b0;
    wait_us(10);
    check(ok_o == 1'b1, "R4/R9", "ok held after idle edges", 64'(ok_o), 1);
    check(data_o == last_good, "R4", "data after idle edges", 64'(data_o), 64'(last_good));

    // R3: start strobes during the frame.
    run_frame(40'h12_34_56_78_9A, 70, 27, 40, 1'b1, "R3 busy start");

    // R8 R10: silent sensor.
    begin
      exp_t e;
      int n;
      e.ok = 1'b0; e.data = last_good; e.tag = "R8/R10 silent";
      exp_q.push_back(e);
      start_and_mark(1'b1);
      n = 0;
      while (!done_o && n < (WDOG + 10) * CPU) begin
        n++;
        @(negedge clk);
      end
      check(n >= (WDOG - 1) * CPU && n <= WDOG * CPU + 4, "R8",
            "timeout length in cycles", 64'(n), 64'(WDOG * CPU));
      wait_empty();
    end

    // R8 R10: frame cut after 20 bits.
    run_frame(40'hFF_FF_FF_FF_FF, 70, 27, 20, 1'b0, "R8/R10 truncated");
    check(ok_o == 1'b0, "R8", "ok after truncated frame", 64'(ok_o), 0);

    wait_us(20);
    check(exp_q.size() == 0, "R3", "pending completions", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule